// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the management master for Ethernet PHYs on a shared two-wire serial bus. It is driven through a single 32-bit command word. A write to that word with the top bit set launches one complete serial frame on the management clock and data lines. The frame is built from the fields of the command word. The same word can be read back at any time. While a frame is in flight its top bit reads as one. When a read frame finishes, the 16 bits the PHY returned appear in its low half.

The start code and opcode fields of the word are sent on the wire exactly as written. Both the short (Clause 22) and the extended (Clause 45) frame formats therefore come from the same path. An extended access takes two commands from software. The first is an address cycle carrying the 16-bit register address. The second, issued once the busy bit reads zero, is the write or read to the same PHY and device.

The management clock comes from a divider on the system clock. The block changes the data line on each falling management-clock edge. The PHY samples it on the rising edge, and the block samples returned data on the rising edge as well. Outside a frame the clock rests low and the data line is released.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word reads 0, the management clock is low and the data line is released (`mdio_oe` = 0).
- R2: Writing a word with bit 31 = 1 while idle sets bit 31 of the read-back word. The bit stays 1 for the whole frame and clears exactly when the frame ends.
- R3: Each frame has 64 bits, sent MSB first in this order: 32 ones; the 2-bit start code from bits 17:16; the 2-bit opcode from bits 19:18; the PHY address from bits 24:20; the register/device field from bits 29:25; 2 turnaround bits; 16 data bits. The data line changes only when the management clock falls.
- R4: For opcodes 0 (extended address cycle) and 1 (write) the block drives the turnaround as 1 then 0, followed by bits 15:0 of the command. After the last bit it releases the line, which then rests high.
- R5: For opcodes 2 and 3 (reads) the block releases the line from the first turnaround bit to the end of the frame. It samples the 16 data bits on the rising edges. When the frame ends it writes them into bits 15:0 and keeps bits 30:16.
- R6: A command write that arrives while bit 31 reads 1 is ignored. The command word and the frame in flight are unchanged.
- R7: The management clock has a period of 2·`DIV_HALF` system clocks. It gives exactly 64 rising edges per frame and is held low while idle.
- R8: Start code and opcode go out verbatim. Start code 01 gives a short frame and 00 gives an extended frame, and all four opcodes work with either start code.
- R9: A command write with bit 31 = 0 while idle stores the word and launches no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Current command word; bit 31 is busy, bits 15:0 hold read data after a read |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data value driven when `mdio_oe` is 1 |
| mdio_oe | output | 1 | Output enable of the data line's tri-state driver |
| mdio_i | input | 1 | Resolved data line value (pulled up when nobody drives) |

## Verification
The assertions assume that `mdio_i` settles between a management-clock fall and the next rise. This holds when the PHY drives only after falling edges. They also assume that the system clock is the only timing reference. The bench PHY model therefore changes its output only after it sees a falling management clock. It drives only from the second turnaround bit through the last data bit of read frames, and no command that follows a busy-clear waits less than one cycle. The busy-time writes in the bench arrive in the middle of a frame so the ignore rule is exercised against a live frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Command word field positions (the register decode depends on these)
  localparam int BUSY_BIT   = 31;
  localparam int RSEL_HI    = 29;
  localparam int RSEL_LO    = 25;
  localparam int PHY_HI     = 24;
  localparam int PHY_LO     = 20;
  localparam int OP_HI      = 19;
  localparam int OP_LO      = 18;
  localparam int ST_HI      = 17;
  localparam int ST_LO      = 16;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = 14;  // start + opcode + phy + reg field

  typedef enum logic [1:0] {
    OPC_XADDR = 2'd0,
    OPC_WRITE = 2'd1,
    OPC_RD_S  = 2'd2,
    OPC_RD_X  = 2'd3
  } mgmt_op_e;

  function automatic logic op_is_read(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic term;

  generate
    if (DIV_HALF == 1) begin : g_nodiv
      assign term = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)                 cnt <= '0;
        else if (cnt == CW'(DIV_HALF-1)) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
      end
      assign term = (cnt == CW'(DIV_HALF-1));
    end
  endgenerate

  assign rise_tick = run && term && !mdc;
  assign fall_tick = run && term &&  mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) mdc <= 1'b0;
    else if (term)   mdc <= ~mdc;
  end

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
  p_rise_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(run));
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int FLEN    = PRE_BITS + HDR_BITS + 2 + DATA_W;
  localparam int IW      = $clog2(FLEN);
  localparam int TA_POS  = PRE_BITS + HDR_BITS;
  localparam int DAT_POS = TA_POS + 2;

  logic [FLEN-1:0] sh;
  logic [IW-1:0]   idx;
  logic            rd_q;
  logic [FLEN-1:0] word;

  assign word = {{PRE_BITS{1'b1}},
                 cmd[ST_HI:ST_LO], cmd[OP_HI:OP_LO],
                 cmd[PHY_HI:PHY_LO], cmd[RSEL_HI:RSEL_LO],
                 2'b10, cmd[DATA_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh      <= word;
        idx     <= '0;
        rd_q    <= op_is_read(cmd[OP_HI:OP_LO]);
        mdio_o  <= word[FLEN-1];
        mdio_oe <= 1'b1;
      end else begin
        if (rise_tick && rd_q && (int'(idx) >= DAT_POS))
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (int'(idx) == FLEN-1) begin
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            idx     <= '0;
          end else begin
            idx    <= idx + 1'b1;
            sh     <= sh << 1;
            mdio_o <= sh[FLEN-2];
            if (rd_q && (int'(idx) + 1 >= TA_POS)) mdio_oe <= 1'b0;
          end
        end
      end
    end
  end

  p_line_moves_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (!fall_tick && !start) |=> $stable(mdio_o));
  p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_q && fall_tick && int'(idx) >= TA_POS-1) |=> !mdio_oe);
  p_end_release_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0]       cmd_q;
  logic              busy;
  logic              start;
  logic              rise_tick, fall_tick;
  logic              done;
  logic [DATA_W-1:0] rdata;

  assign busy      = cmd_q[BUSY_BIT];
  assign start     = cmd_we && !busy && cmd_wdata[BUSY_BIT];
  assign cmd_rdata = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (cmd_we && !busy) begin
      cmd_q <= cmd_wdata;
    end else if (done) begin
      cmd_q[BUSY_BIT] <= 1'b0;
      if (op_is_read(cmd_q[OP_HI:OP_LO])) cmd_q[DATA_W-1:0] <= rdata;
    end
  end

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) i_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) i_shift (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rdata(rdata)
  );

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  p_done_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  p_ignore_busy_write_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (cmd_q == $past(cmd_q)));
  p_store_no_launch_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !busy && !cmd_wdata[BUSY_BIT]) |=> !busy);
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int DIV_HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0, phy_o = 1'b1;
  logic        mdio_line;

  assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.DIV_HALF(DIV_HALF), .PRE_BITS(32)) i_mdio_master (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_line)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int rise_cnt = 0, last_rise = 0, gap = 0;
  logic [63:0] cap = '0;
  logic phy_rd = 1'b0, clash = 1'b0, prev_mdc = 1'b0;
  logic [15:0] phy_val = '0;

  // Bus monitor and PHY model, acting between clock edges
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (!rst) begin
      if (mdio_oe && phy_oe) clash = 1'b1;
      if (mdc && !prev_mdc) begin
        cap = {cap[62:0], mdio_line};
        rise_cnt++;
        gap = cyc - last_rise;
        last_rise = cyc;
      end
      if (!mdc && prev_mdc) begin
        if (phy_rd && rise_cnt >= 47 && rise_cnt <= 63) begin
          phy_oe = 1'b1;
          phy_o  = (rise_cnt == 47) ? 1'b0 : phy_val[63-rise_cnt];
        end else begin
          phy_oe = 1'b0;
        end
      end
      prev_mdc = mdc;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000 && cmd_rdata[31]; n++) @(negedge clk);
  endtask

  task automatic do_frame(input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] dat);
    logic [31:0] cmd;
    logic [63:0] expf;
    logic [31:0] expr;
    cmd = {1'b1, 1'b0, rg, phy, op, st, dat};
    rise_cnt = 0; cap = '0; clash = 1'b0;
    phy_rd = op[1]; phy_val = dat ^ 16'hA5C3;
    write_cmd(cmd);
    chk(cmd_rdata[31] == 1'b1, "R2 busy after launch", 64'(cmd_rdata[31]), 64'd1);
    wait_idle();
    @(negedge clk);
    if (op[1]) begin
      expf = {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, phy_val};
      expr = {1'b0, cmd[30:16], phy_val};
      chk(cap == expf, "R5 R8 read frame on wire", cap, expf);
      chk(cmd_rdata == expr, "R5 captured data in word", 64'(cmd_rdata), 64'(expr));
      chk(!clash, "R5 line released during read", 64'(clash), 64'd0);
    end else begin
      expf = {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, dat};
      expr = {1'b0, cmd[30:0]};
      chk(cap == expf, "R3 R4 R8 write/address frame on wire", cap, expf);
      chk(cmd_rdata == expr, "R2 busy cleared, word kept", 64'(cmd_rdata), 64'(expr));
    end
    chk(rise_cnt == 64, "R7 rising edges per frame", 64'(rise_cnt), 64'd64);
    chk(gap == 2*DIV_HALF, "R7 clock period", 64'(gap), 64'(2*DIV_HALF));
    chk(!mdc && !mdio_oe && mdio_line, "R4 R7 idle after frame",
        64'({mdc, mdio_oe, mdio_line}), 64'b001);
  endtask

  initial begin
    logic [31:0] first;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_rdata == 32'd0 && !mdc && !mdio_oe, "R1 reset state",
        64'({cmd_rdata, mdc, mdio_oe}), 64'd0);

    // Sweep both start codes, all four opcodes, three field patterns
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 3; p++)
          do_frame(2'(s), 2'(o), 5'(p*11 + o + 1), 5'(p*7 + s*3 + 5),
                   (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : 16'(16'h00B3 * (o*2 + s + 3)));

    // R9: store without launching
    rise_cnt = 0;
    write_cmd(32'h1234_5678);
    repeat (20) @(negedge clk);
    chk(rise_cnt == 0 && !mdc, "R9 no frame when bit31 clear", 64'(rise_cnt), 64'd0);
    chk(cmd_rdata == 32'h1234_5678, "R9 word stored", 64'(cmd_rdata), 64'h1234_5678);

    // R6: write during a frame is ignored
    rise_cnt = 0; cap = '0; phy_rd = 1'b0;
    first = {1'b1, 1'b0, 5'd3, 5'd9, 2'd1, 2'd1, 16'hC0DE};
    write_cmd(first);
    repeat (30) @(negedge clk);
    write_cmd({1'b1, 1'b0, 5'd31, 5'd31, 2'd2, 2'd0, 16'h1111});
    chk(cmd_rdata == first, "R6 word unchanged by busy write", 64'(cmd_rdata), 64'(first));
    wait_idle();
    @(negedge clk);
    chk(cap == {32'hFFFF_FFFF, 2'd1, 2'd1, 5'd9, 5'd3, 2'b10, 16'hC0DE},
        "R6 frame unaffected", cap, {32'hFFFF_FFFF, 2'd1, 2'd1, 5'd9, 5'd3, 2'b10, 16'hC0DE});
    chk(rise_cnt == 64, "R6 single frame", 64'(rise_cnt), 64'd64);
    chk(cmd_rdata == {1'b0, first[30:0]}, "R6 R2 final word", 64'(cmd_rdata), 64'({1'b0, first[30:0]}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule